// File: doc/BRIEF.md
# Magnitude Running Average

This block turns a stream of wide signed samples into a slowly varying level estimate. When the input strobe is high, it takes the absolute value of the sample and shifts it right by a fixed amount to get a 16-bit scaled magnitude. It then keeps a running sum over the most recent 1024 scaled values.

The sum is updated recursively. A 1024-entry circular buffer holds the scaled history. On each strobe the entry under the write pointer is read as the oldest value and then overwritten with the newest one. The sum gains the newest value and loses the oldest. The reported level is the sum shifted right by ten bits, which is the mean of the window, and it comes with its own strobe. A filter output feeds the block, and the level it produces is large when the filter passes the input tone and small when the filter blocks it.

Top module: `mag_avg`

## Requirements
- R1: While reset is low and on the first sampling point after reset, `out_valid` is 0 and `out_avg` is 0.
- R2: The magnitude is the absolute value of the 44-bit two's-complement input. The most negative input, -2^43, gives magnitude 2^43 and scaled value 32768. It does not wrap.
- R3: The scaled value is the magnitude shifted right by 28 bits, discarding the fraction. A magnitude of 2^28-1 adds 0 and a magnitude of 2^28 adds 1.
- R4: `out_valid` is high for exactly the one cycle after each cycle where `in_valid` is high, and low otherwise. Back-to-back strobes give back-to-back outputs.
- R5: Cycles with `in_valid` low have no effect. `out_avg` holds its value and the sample window does not change.
- R6: After each strobe, `out_avg` equals floor(S/1024), where S is the sum of the scaled values of the last 1024 strobed samples. While fewer than 1024 samples have arrived, the missing entries count as 0.
- R7: Once the window is full, each new sample displaces the sample taken 1024 strobes earlier. The buffer position wraps from 1023 back to 0.
- R8: The 26-bit accumulator does not overflow. A window of 1024 samples at full scale gives `out_avg` = 32768.
- R9: Asserting reset in the middle of a run discards all history. The first sample after reset is averaged against an empty window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 44 | Signed input sample |
| out_valid | output | 1 | Strobe for an updated average |
| out_avg | output | 16 | Window mean of the scaled magnitudes |

## Verification
The in-module assertions check three things on every cycle:
- the one-cycle strobe timing;
- that the level holds on idle cycles;
- that the buffer position advances and wraps correctly, and that the sum stays under its fill bound before the first wrap.

The arithmetic can only be shown by the bench's scenarios, which compare against an independent window model. These scenarios cover:
- the absolute value at the most negative input;
- the truncation boundary at 2^28;
- the eviction of old samples after the buffer wraps;
- the full-scale window;
- the history being cleared by a mid-run reset.

// File: rtl/mag_avg.sv
module mag_avg #(
  parameter int IN_W      = 44,
  parameter int SHIFT     = 28,
  parameter int OUT_W     = 16,
  parameter int DEPTH_LOG = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_avg
);
  localparam int DEPTH = 1 << DEPTH_LOG;
  localparam int SUM_W = OUT_W + DEPTH_LOG;

  logic [IN_W-1:0]      mag;
  logic [OUT_W-1:0]     scaled, oldest;
  logic [OUT_W-1:0]     hist [DEPTH];
  logic [DEPTH_LOG-1:0] ptr;
  logic                 wrapped;
  logic [SUM_W-1:0]     sum;

  assign mag    = in_sample[IN_W-1] ? (~in_sample + 1'b1) : in_sample;
  assign scaled = mag[SHIFT +: OUT_W];
  assign oldest = wrapped ? hist[ptr] : '0;
  assign out_avg = sum[SUM_W-1 -: OUT_W];

  always_ff @(posedge clk)
    if (in_valid) hist[ptr] <= scaled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      wrapped   <= 1'b0;
      sum       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum <= sum + SUM_W'(scaled) - SUM_W'(oldest);
        ptr <= ptr + 1'b1;
        if (ptr == DEPTH_LOG'(DEPTH - 1)) wrapped <= 1'b1;
      end
    end
  end

  assert_strobe_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_avg) && $stable(ptr));
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ptr == DEPTH_LOG'(DEPTH - 1)) |=> (ptr == '0 && wrapped));
  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrapped |-> (32'(sum) <= 32'(ptr) * ((32'd1 << OUT_W) - 1)));
  assert_scale_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> 32'(scaled) <= (32'd1 << (IN_W - 1 - SHIFT)));
endmodule

// File: tb/mag_avg_bench.sv
module mag_avg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [43:0] in_sample = '0;
  logic        out_valid;
  logic [15:0] out_avg;

  int n_checks = 0, n_fail = 0;
  int hist [1024];
  int wp = 0;
  longint msum = 0;
  logic [15:0] last_avg = '0;

  always #4 clk = ~clk;

  mag_avg u_mag_avg (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
                     .out_valid(out_valid), .out_avg(out_avg));

  function automatic int scale_of(logic [43:0] x);
    longint m;
    m = x[43] ? (64'sd1 <<< 44) - longint'({20'd0, x}) : longint'({20'd0, x});
    return int'(m >>> 28);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) hist[i] = 0;
    wp = 0; msum = 0; last_avg = '0;
  endtask

  task automatic send(logic [43:0] x, string req);
    int s;
    s = scale_of(x);
    msum = msum + s - hist[wp];
    hist[wp] = s;
    wp = (wp + 1) % 1024;
    in_valid = 1'b1; in_sample = x;
    @(negedge clk);
    check({req, " R4 strobe"}, out_valid, 1);
    check({req, " R6 avg"}, out_avg, msum >>> 10);
    last_avg = out_avg;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    in_sample = {$urandom, $urandom};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R4 no strobe", out_valid, 0);
      check("R5 idle hold", out_avg, last_avg);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    check("R1 avg in reset", out_avg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 0);
    check("R1 avg after reset", out_avg, 0);
    model_clear();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    @(negedge clk);
    do_reset();

    // R2, R3 directed corners
    send(44'h800_0000_0000, "R2 most negative");
    send(44'h000_0FFF_FFFF, "R3 below step");
    send(44'h000_1000_0000, "R3 one step");
    send(44'hFFF_F000_0000, "R2 negative one step");
    send(44'hFFF_FFFF_FFFF, "R2 minus one");
    idle(3);

    // R6, R7 random run over several wraps, with gaps and bursts
    for (int i = 0; i < 2600; i++) begin
      logic [43:0] v;
      v = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) v = 44'(signed'(v) >>> $urandom_range(0, 20));
      send(v, "R7 random");
      if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
    end
    idle(2);

    // R8 full-scale window
    for (int i = 0; i < 1024; i++) send(44'h800_0000_0000, "R8 full scale");
    check("R8 full avg", out_avg, 32768);
    for (int i = 0; i < 1024; i++) send(44'h000_0000_0000, "R7 drain");
    check("R7 drained", out_avg, 0);

    // R9 mid-run reset discards history
    for (int i = 0; i < 300; i++) send(44'h7FF_FFFF_FFFF, "R9 prefill");
    do_reset();
    send(44'h000_0400_0000_0 >> 4, "R9 after reset");
    for (int i = 0; i < 1030; i++) send(44'h400_0000_0000, "R9 refill");
    check("R9 refill avg", out_avg, 16384);
    idle(2);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule